// File: doc/BRIEF.md
# Segment Limit and Access Checker

This block sits in front of address generation and decides whether a single data access made through a segment register may proceed. For each request it takes the segment's cached descriptor attributes (present bit, read and write permission flags, type code, limit and base), the offset, the access width and the direction. From these it produces one registered response a cycle later. A permitted access comes back with its linear address, a routing hint (straight to memory in real mode, or to translation with the current privilege tag in protected mode) and the length and kind needed by a debug breakpoint comparator. A refused access comes back with a two-bit fault code.

Segments whose type marks them as growing downward use an inverted limit test. Which types count as growing downward depends on the direction: a read treats more types that way than a write does. When the descriptor does not grant the requested permission, the access skips the fast limit test and is marked for a separate slow-path handler. All limit arithmetic wraps modulo 2^32.

Top module: `seg_access_check`

## Requirements
- R1: After synchronous reset, `rsp_valid`, `rsp_grant` and `rsp_fault` are all 0.
- R2: Each request with `req_valid` high produces exactly one response with `rsp_valid` high on the next clock edge. A cycle with no request produces `rsp_valid` low, and then all other response fields read 0.
- R3: A request whose descriptor present bit `desc_valid` is 0 gets fault code 2'b01 (general protection), whatever the segment index and flags.
- R4: A present descriptor without `desc_rd` on a read (`req_write`=0), or without `desc_wr` on a write (`req_write`=1), gets fault code 2'b11 (slow path) and no grant. This happens before any limit test.
- R5: Reads treat type codes 4, 5, 6 and 7 as growing downward. Writes treat only 6 and 7 that way. All other codes use the normal test.
- R6: On a downward-growing segment, the access faults when (offset − (bytes−1)) mod 2^32 ≤ limit.
- R7: On a normal segment, the access faults when offset > (limit − (bytes−1)) mod 2^32. Width code `req_size` is 2'b00 = 1 byte, 2'b01 = 2 bytes, 2'b10 and 2'b11 = 4 bytes.
- R8: A limit fault through segment index 2 (the stack register) gives fault code 2'b10. Through any other index it gives 2'b01. The error code is zero in both cases.
- R9: A permitted access gives `rsp_grant`=1, fault code 2'b00 and `rsp_lin_addr` = (base + offset) mod 2^32. A refused access gives `rsp_lin_addr` = 0.
- R10: On a permitted access, `rsp_bp_len` is bytes−1 (0, 1 or 3) and `rsp_bp_rw` is 1 for a write (read-write kind) or 0 for a read (read-only kind). Both are 0 when the access is refused.
- R11: On a permitted access, real mode (`prot_mode`=0) gives `rsp_direct`=1 and `rsp_xlat`=0. Protected mode gives `rsp_xlat`=1 with `rsp_user` equal to `user_mode`. All three are 0 when the access is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_seg | input | 3 | Segment register index (2 = stack) |
| desc_valid | input | 1 | Descriptor present bit |
| desc_rd | input | 1 | Descriptor readable flag |
| desc_wr | input | 1 | Descriptor writable flag |
| desc_type | input | 4 | Descriptor type code |
| desc_limit | input | 32 | Segment limit |
| desc_base | input | 32 | Segment base |
| req_offset | input | 32 | Access offset |
| req_size | input | 2 | Access width code |
| req_write | input | 1 | 1 = write, 0 = read |
| prot_mode | input | 1 | 1 = protected mode |
| user_mode | input | 1 | Current privilege is user |
| rsp_valid | output | 1 | Response strobe |
| rsp_grant | output | 1 | Access permitted |
| rsp_fault | output | 2 | 00 none, 01 general protection, 10 stack, 11 slow path |
| rsp_lin_addr | output | 32 | Linear address |
| rsp_direct | output | 1 | Send straight to memory |
| rsp_xlat | output | 1 | Send to translation |
| rsp_user | output | 1 | Privilege tag for translation |
| rsp_bp_len | output | 2 | Breakpoint length, bytes minus one |
| rsp_bp_rw | output | 1 | Breakpoint kind, 1 = read-write |

## Verification
The block keeps no state between requests, so any internal error shows up in the response to the request that caused it, one cycle later. It cannot appear on a later request. A wrong downward-growth decision or a wrong span shows as a wrong fault code right at the limit boundary, so the directed cases place offsets exactly on and one past the limit for every width. A wrong priority among the present bit, the permission flags and the limit test shows as a fault code swapped between 01, 10 and 11. A slip in the address sum or in the routing fields shows on the same response as a wrong `rsp_lin_addr`, `rsp_direct`/`rsp_xlat` or breakpoint field.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_GP   = 2'b01,
    FLT_SS   = 2'b10,
    FLT_SLOW = 2'b11
  } fault_e;

  // width code to (bytes - 1)
  function automatic logic [1:0] span_of(input logic [1:0] size_code);
    case (size_code)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/seg_kind_classify.sv
module seg_kind_classify #(
  parameter int TYPE_W = 4
) (
  input  logic              is_write,
  input  logic [TYPE_W-1:0] desc_type,
  input  logic              readable,
  input  logic              writable,
  output logic              expand_down,
  output logic              need_slow
);
  localparam logic [TYPE_W-1:0] T_LO_RD = TYPE_W'(4);
  localparam logic [TYPE_W-1:0] T_LO_WR = TYPE_W'(6);
  localparam logic [TYPE_W-1:0] T_HI    = TYPE_W'(7);

  logic down_rd, down_wr;

  // reads see a wider set of downward-growing types than writes
  assign down_rd     = (desc_type >= T_LO_RD) && (desc_type <= T_HI);
  assign down_wr     = (desc_type >= T_LO_WR) && (desc_type <= T_HI);
  assign expand_down = is_write ? down_wr : down_rd;
  assign need_slow   = is_write ? !writable : !readable;
endmodule

// File: rtl/seg_limit_cmp.sv
module seg_limit_cmp
  import seg_chk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] offset,
  input  logic [AW-1:0] limit,
  input  logic [1:0]    size_code,
  input  logic          expand_down,
  output logic [1:0]    span,
  output logic          over_limit
);
  logic [AW-1:0] span_w, low_end, top_ok;

  assign span    = span_of(size_code);
  assign span_w  = AW'(span);
  // modular subtraction on purpose: wrap follows the rule set
  assign low_end = offset - span_w;
  assign top_ok  = limit - span_w;

  always_comb begin
    if (expand_down) over_limit = (low_end <= limit);
    else             over_limit = (offset > top_ok);
  end
endmodule

// File: rtl/seg_resp_reg.sv
module seg_resp_reg
  import seg_chk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          d_valid,
  input  logic          d_grant,
  input  fault_e        d_fault,
  input  logic [AW-1:0] d_addr,
  input  logic          d_direct,
  input  logic          d_xlat,
  input  logic          d_user,
  input  logic [1:0]    d_len,
  input  logic          d_rw,
  output logic          q_valid,
  output logic          q_grant,
  output fault_e        q_fault,
  output logic [AW-1:0] q_addr,
  output logic          q_direct,
  output logic          q_xlat,
  output logic          q_user,
  output logic [1:0]    q_len,
  output logic          q_rw
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid  <= 1'b0;
      q_grant  <= 1'b0;
      q_fault  <= FLT_NONE;
      q_addr   <= '0;
      q_direct <= 1'b0;
      q_xlat   <= 1'b0;
      q_user   <= 1'b0;
      q_len    <= 2'd0;
      q_rw     <= 1'b0;
    end else begin
      q_valid  <= d_valid;
      q_grant  <= d_grant;
      q_fault  <= d_fault;
      q_addr   <= d_addr;
      q_direct <= d_direct;
      q_xlat   <= d_xlat;
      q_user   <= d_user;
      q_len    <= d_len;
      q_rw     <= d_rw;
    end
  end
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import seg_chk_pkg::*;
#(
  parameter int AW     = 32,
  parameter int IDX_W  = 3,
  parameter int TYPE_W = 4,
  parameter int SS_IDX = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_seg,
  input  logic              desc_valid,
  input  logic              desc_rd,
  input  logic              desc_wr,
  input  logic [TYPE_W-1:0] desc_type,
  input  logic [AW-1:0]     desc_limit,
  input  logic [AW-1:0]     desc_base,
  input  logic [AW-1:0]     req_offset,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic              prot_mode,
  input  logic              user_mode,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic [1:0]        rsp_fault,
  output logic [AW-1:0]     rsp_lin_addr,
  output logic              rsp_direct,
  output logic              rsp_xlat,
  output logic              rsp_user,
  output logic [1:0]        rsp_bp_len,
  output logic              rsp_bp_rw
);
  localparam logic [IDX_W-1:0] STACK_SEG = IDX_W'(SS_IDX);

  logic          expand_down, need_slow, over_limit, grant_n;
  logic [1:0]    span;
  fault_e        fault_n, fault_q;
  logic [AW-1:0] addr_n;

  seg_kind_classify #(.TYPE_W(TYPE_W)) u_kind (
    .is_write(req_write), .desc_type(desc_type),
    .readable(desc_rd), .writable(desc_wr),
    .expand_down(expand_down), .need_slow(need_slow)
  );

  seg_limit_cmp #(.AW(AW)) u_cmp (
    .offset(req_offset), .limit(desc_limit), .size_code(req_size),
    .expand_down(expand_down), .span(span), .over_limit(over_limit)
  );

  // priority: present bit, then permission, then limit
  always_comb begin
    if (!req_valid)       fault_n = FLT_NONE;
    else if (!desc_valid) fault_n = FLT_GP;
    else if (need_slow)   fault_n = FLT_SLOW;
    else if (over_limit)  fault_n = (req_seg == STACK_SEG) ? FLT_SS : FLT_GP;
    else                  fault_n = FLT_NONE;
  end

  assign grant_n = req_valid && (fault_n == FLT_NONE);
  assign addr_n  = grant_n ? (desc_base + req_offset) : '0;

  seg_resp_reg #(.AW(AW)) u_out (
    .clk(clk), .rst(rst),
    .d_valid(req_valid), .d_grant(grant_n), .d_fault(fault_n),
    .d_addr(addr_n),
    .d_direct(grant_n && !prot_mode),
    .d_xlat(grant_n && prot_mode),
    .d_user(grant_n && prot_mode && user_mode),
    .d_len(grant_n ? span : 2'd0),
    .d_rw(grant_n && req_write),
    .q_valid(rsp_valid), .q_grant(rsp_grant), .q_fault(fault_q),
    .q_addr(rsp_lin_addr), .q_direct(rsp_direct), .q_xlat(rsp_xlat),
    .q_user(rsp_user), .q_len(rsp_bp_len), .q_rw(rsp_bp_rw)
  );

  assign rsp_fault = fault_q;

  // R2: one response per request, one cycle later
  a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && !rsp_grant);
  // R3: absent descriptor always general protection
  a_r3_absent_is_gp: assert property (@(posedge clk) disable iff (rst)
    req_valid && !desc_valid |=> rsp_fault == 2'b01);
  // R8: stack fault only through the stack register
  a_r8_ss_only_stack: assert property (@(posedge clk) disable iff (rst)
    req_valid && (req_seg != STACK_SEG) |=> rsp_fault != 2'b10);
  // R9: grant and fault are exclusive
  a_r9_grant_no_fault: assert property (@(posedge clk) disable iff (rst)
    rsp_grant |-> rsp_valid && rsp_fault == 2'b00);
  // R11: at most one route, only on grant
  a_r11_one_route: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_direct, rsp_xlat}) && ((rsp_direct || rsp_xlat) == rsp_grant));
endmodule

// File: tb/tb_seg_access_check.sv
`timescale 1ns/1ps
module tb_seg_access_check;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, desc_valid, desc_rd, desc_wr, req_write, prot_mode, user_mode;
  logic [2:0]  req_seg;
  logic [3:0]  desc_type;
  logic [31:0] desc_limit, desc_base, req_offset;
  logic [1:0]  req_size;
  logic        rsp_valid, rsp_grant, rsp_direct, rsp_xlat, rsp_user, rsp_bp_rw;
  logic [1:0]  rsp_fault, rsp_bp_len;
  logic [31:0] rsp_lin_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  seg_access_check dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_seg(req_seg),
    .desc_valid(desc_valid), .desc_rd(desc_rd), .desc_wr(desc_wr),
    .desc_type(desc_type), .desc_limit(desc_limit), .desc_base(desc_base),
    .req_offset(req_offset), .req_size(req_size), .req_write(req_write),
    .prot_mode(prot_mode), .user_mode(user_mode),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault),
    .rsp_lin_addr(rsp_lin_addr), .rsp_direct(rsp_direct), .rsp_xlat(rsp_xlat),
    .rsp_user(rsp_user), .rsp_bp_len(rsp_bp_len), .rsp_bp_rw(rsp_bp_rw)
  );

  function automatic logic [1:0] ref_fault(input logic [2:0] seg, input logic dv,
      input logic rd, input logic wr, input logic [3:0] typ, input logic [31:0] lim,
      input logic [31:0] off, input logic [1:0] sz, input logic w);
    logic [31:0] sp;
    logic down, bad;
    sp = (sz == 2'b00) ? 32'd0 : (sz == 2'b01) ? 32'd1 : 32'd3;
    if (!dv) return 2'b01;
    if (w ? !wr : !rd) return 2'b11;
    down = w ? (typ == 4'd6 || typ == 4'd7) : (typ >= 4'd4 && typ <= 4'd7);
    bad  = down ? ((off - sp) <= lim) : (off > (lim - sp));
    if (bad) return (seg == 3'd2) ? 2'b10 : 2'b01;
    return 2'b00;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] seg, input logic dv, input logic rd,
      input logic wr, input logic [3:0] typ, input logic [31:0] lim,
      input logic [31:0] base, input logic [31:0] off, input logic [1:0] sz,
      input logic w, input logic pm, input logic um, input string ftag);
    logic [1:0] ef;
    logic g;
    @(negedge clk);
    req_valid = 1; req_seg = seg; desc_valid = dv; desc_rd = rd; desc_wr = wr;
    desc_type = typ; desc_limit = lim; desc_base = base; req_offset = off;
    req_size = sz; req_write = w; prot_mode = pm; user_mode = um;
    ef = ref_fault(seg, dv, rd, wr, typ, lim, off, sz, w);
    g  = (ef == 2'b00);
    @(negedge clk);
    req_valid = 0;
    check({"R2 valid ", ftag}, 32'(rsp_valid), 32'd1);
    check({"fault ", ftag}, 32'(rsp_fault), 32'(ef));
    check("R9 grant", 32'(rsp_grant), 32'(g));
    check("R9 lin_addr", rsp_lin_addr, g ? base + off : 32'd0);
    check("R10 bp_len", 32'(rsp_bp_len),
          g ? ((sz == 2'b00) ? 32'd0 : (sz == 2'b01) ? 32'd1 : 32'd3) : 32'd0);
    check("R10 bp_rw", 32'(rsp_bp_rw), 32'(g && w));
    check("R11 direct", 32'(rsp_direct), 32'(g && !pm));
    check("R11 xlat", 32'(rsp_xlat), 32'(g && pm));
    check("R11 user", 32'(rsp_user), 32'(g && pm && um));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst = 1; req_valid = 0; req_seg = 0; desc_valid = 0; desc_rd = 0; desc_wr = 0;
    desc_type = 0; desc_limit = 0; desc_base = 0; req_offset = 0; req_size = 0;
    req_write = 0; prot_mode = 0; user_mode = 0;
    repeat (3) @(negedge clk);
    check("R1 valid", 32'(rsp_valid), 32'd0);
    check("R1 grant", 32'(rsp_grant), 32'd0);
    check("R1 fault", 32'(rsp_fault), 32'd0);
    rst = 0;
    @(negedge clk);
    check("R2 idle", 32'(rsp_valid), 32'd0);

    // R3 absent descriptor, even via stack index and out of limit
    send(3'd2, 0, 1, 1, 4'd2, 32'h10, 32'h0, 32'h100, 2'b10, 0, 1, 0, "R3");
    // R4 permission routes to slow path before limit
    send(3'd1, 1, 0, 1, 4'd2, 32'h10, 32'h0, 32'h100, 2'b00, 0, 0, 0, "R4 rd");
    send(3'd2, 1, 1, 0, 4'd2, 32'hffff, 32'h0, 32'h4, 2'b01, 1, 0, 0, "R4 wr");
    // R5/R6 type 4 read grows downward
    send(3'd3, 1, 1, 1, 4'd4, 32'h100, 32'h0, 32'h100, 2'b00, 0, 1, 1, "R6 on");
    send(3'd3, 1, 1, 1, 4'd4, 32'h100, 32'h0, 32'h101, 2'b00, 0, 1, 1, "R6 past");
    send(3'd3, 1, 1, 1, 4'd5, 32'h100, 32'h0, 32'h103, 2'b10, 0, 1, 0, "R6 dw on");
    send(3'd3, 1, 1, 1, 4'd5, 32'h100, 32'h0, 32'h104, 2'b11, 0, 1, 0, "R6 dw past");
    // R5 type 4 write uses normal test; type 6 write grows downward
    send(3'd0, 1, 1, 1, 4'd4, 32'h100, 32'h0, 32'h100, 2'b00, 1, 0, 0, "R5 wr4");
    send(3'd0, 1, 1, 1, 4'd6, 32'h100, 32'h0, 32'h100, 2'b00, 1, 0, 0, "R5 wr6");
    // R7 normal boundary with 2 bytes
    send(3'd1, 1, 1, 1, 4'd2, 32'hff, 32'h1000, 32'hfe, 2'b01, 0, 0, 0, "R7 in");
    send(3'd1, 1, 1, 1, 4'd2, 32'hff, 32'h1000, 32'hff, 2'b01, 0, 0, 0, "R7 out");
    // R7 wrap: limit 0, 4 bytes at offset 0 passes by modular rule
    send(3'd1, 1, 1, 1, 4'd0, 32'h0, 32'h0, 32'h0, 2'b10, 0, 0, 0, "R7 wrap");
    // R8 stack vs other register
    send(3'd2, 1, 1, 1, 4'd2, 32'h20, 32'h0, 32'h21, 2'b00, 1, 1, 0, "R8 ss");
    send(3'd5, 1, 1, 1, 4'd2, 32'h20, 32'h0, 32'h21, 2'b00, 1, 1, 0, "R8 other");
    // R9 address wrap, R11 user tag
    send(3'd4, 1, 1, 1, 4'd2, 32'hffff_ffff, 32'hffff_fff0, 32'h20, 2'b10, 1, 1, 1, "R9 wrap");
    @(negedge clk);
    check("R2 idle after", 32'(rsp_valid), 32'd0);
    check("R2 idle addr", rsp_lin_addr, 32'd0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] lim, off, d;
      lim = $urandom;
      d   = 32'($urandom_range(0, 8)) - 32'd4;
      off = ($urandom_range(0, 3) == 0) ? $urandom : lim + d;
      send(3'($urandom), ($urandom_range(0, 15) != 0), ($urandom_range(0, 7) != 0),
           ($urandom_range(0, 7) != 0), 4'($urandom), lim, $urandom, off,
           2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R5-mix R6 R7 R8");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule